// File: doc/BRIEF.md
# Single-Pin Synchronous Serial Shifter

This block is a W-bit clock-synchronous serial port that sits on a microcontroller's internal bus. It sends and receives over one data line, least significant bit first, so the same shift register carries the outgoing byte out and the incoming byte in. The host starts a transfer by writing the data register, which loads the shift register. Once the port signals completion, the host reads the register to get the received byte.

The transfer clock comes from one of two sources. In internal mode the block divides its own system clock by a fixed half-period parameter and drives the result on `sclk_out`. In external mode it follows `sclk_in`. That pin and `sdata_in` each pass through a two-flop synchronizer, and their edges are detected in the system clock domain. The new bit is driven on each falling transfer-clock edge. The line is sampled and the register shifts on each rising edge.

The two modes end a transfer differently. In internal mode the block stops the clock high and releases the data line. In external mode it keeps the line driven and goes on shifting for as long as edges arrive. In both modes the port gives one single-cycle interrupt pulse and sets a level completion flag.

Top module: `sio_shifter`

## Requirements
- R1: After reset, `sclk_out` is 1, `sdata_oe` is 0, `irq` is 0, `done` is 0 and `rd_data` is 0.
- R2: A cycle with `wr_en` high loads `wr_data` into the shift register, clears `done`, sets `sdata_oe` and starts a W-bit transfer. In the following cycle `rd_data` equals the written value.
- R3: Bits leave on `sdata_out` least significant first, D0 through D(W-1). Each bit is presented after a falling edge of the transfer clock.
- R4: On every rising edge of the transfer clock the synchronized `sdata_in` enters at the most significant end and the register moves one place toward bit 0. After W edges, the first bit received is in `rd_data[0]`.
- R5: In internal mode (`ext_mode` = 0), `sclk_out` idles at 1. A transfer makes exactly W low phases, each HALF system clocks long, and `sclk_out` stays 1 after the last rising edge.
- R6: At the end of an internal-mode transfer, `irq` pulses, `done` sets and `sdata_oe` returns to 0.
- R7: In external mode (`ext_mode` = 1), `irq` pulses and `done` sets after the W-th rising edge of `sclk_in`, and `sdata_oe` stays 1. Further `sclk_in` edges without a new write keep shifting `rd_data` and raise no further `irq`.
- R8: A cycle with `rd_en` high clears `done`, unless completion happens in that same cycle.
- R9: `irq` is high for exactly one system clock cycle, and only once per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the data register |
| wr_data | input | W | Byte to transmit |
| rd_en | input | 1 | Host read strobe; clears the completion flag |
| rd_data | output | W | Shift register contents |
| ext_mode | input | 1 | 1 selects `sclk_in` as the transfer clock, 0 the internal divider |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock, idle high |
| sdata_in | input | 1 | Data line as seen at the pin |
| sdata_out | output | 1 | Value driven onto the data line |
| sdata_oe | output | 1 | Output enable for the data line |
| irq | output | 1 | Single-cycle completion interrupt |
| done | output | 1 | Shift-completion flag |

## Verification
The bench builds the block with W = 8 and shortens the divider to HALF = 4. A whole internal transfer then lasts about 70 cycles, so many patterns in both modes fit easily. Four cycles per half period still leave room for the two-flop input synchronizer. The bench can therefore change `sdata_in` on the falling edge it sees and still have the value sampled on the next rising edge. In external mode the bench generates `sclk_in` with six-cycle half periods. This allows for the three-cycle edge-detection latency and makes the post-completion shifting and the retained output enable observable.

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W    = 8,
  parameter int HALF = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         ext_mode,
  input  logic         sclk_in,
  output logic         sclk_out,
  input  logic         sdata_in,
  output logic         sdata_out,
  output logic         sdata_oe,
  output logic         irq,
  output logic         done
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam int DW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);
  localparam logic [DW-1:0] DIV_TOP  = DW'(HALF - 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic [DW-1:0] div;
  logic [2:0]    ck_s;
  logic [1:0]    d_s;
  logic          busy, sclk_int, obit, oe;

  wire run_int  = busy & ~ext_mode;
  wire tick     = run_int & (div == DIV_TOP);
  wire ext_rise = ck_s[1] & ~ck_s[2];
  wire ext_fall = ~ck_s[1] & ck_s[2];
  wire rise     = ext_mode ? ext_rise : (tick & ~sclk_int);
  wire fall     = ext_mode ? ext_fall : (tick & sclk_int);
  wire finish   = rise & busy & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= 3'b111;
      d_s  <= 2'b00;
    end else begin
      ck_s <= {ck_s[1:0], sclk_in};
      d_s  <= {d_s[0], sdata_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      div      <= '0;
      busy     <= 1'b0;
      sclk_int <= 1'b1;
      obit     <= 1'b0;
      oe       <= 1'b0;
      done     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_en) begin
        shreg    <= wr_data;
        cnt      <= LAST_BIT;
        div      <= '0;
        busy     <= 1'b1;
        sclk_int <= 1'b1;
        oe       <= 1'b1;
        done     <= 1'b0;
      end else begin
        if (run_int) div <= (div == DIV_TOP) ? '0 : div + 1'b1;
        if (tick) sclk_int <= ~sclk_int;
        if (fall) obit <= shreg[0];
        if (rise) shreg <= {d_s[1], shreg[W-1:1]};
        if (rise && busy && cnt != '0) cnt <= cnt - 1'b1;
        if (finish) begin
          busy <= 1'b0;
          irq  <= 1'b1;
          done <= 1'b1;
          if (!ext_mode) oe <= 1'b0;
        end else if (rd_en) begin
          done <= 1'b0;
        end
      end
    end
  end

  assign rd_data   = shreg;
  assign sclk_out  = sclk_int;
  assign sdata_out = obit;
  assign sdata_oe  = oe;
endmodule

// File: rtl/sio_shifter_chk.sv
module sio_shifter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         rd_en,
  input logic [W-1:0] rd_data,
  input logic         ext_mode,
  input logic         sclk_out,
  input logic         sdata_oe,
  input logic         irq,
  input logic         done
);
  // R2
  write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!done && sdata_oe && rd_data == $past(wr_data)));

  // R5
  int_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !sdata_oe) |-> sclk_out);

  // R6
  int_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ext_mode) |-> (done && !sdata_oe && sclk_out));

  // R7
  ext_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ext_mode) |-> (done && sdata_oe));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> (!done || irq));

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind sio_shifter sio_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .ext_mode(ext_mode),
  .sclk_out(sclk_out), .sdata_oe(sdata_oe), .irq(irq), .done(done)
);

// File: tb/sim_sio_shifter.sv
`timescale 1ns/1ps
module sim_sio_shifter;
  localparam int W = 8;
  localparam int HALF = 4;
  localparam int EXT_HP = 6;
  localparam int NV = 6;
  // {ext_mode, tx byte, rx byte}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h5A, 8'hC3},
    {1'b0, 8'h01, 8'h80},
    {1'b1, 8'h00, 8'hFF},
    {1'b0, 8'h80, 8'h01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ext_mode = 1'b0;
  logic sclk_in = 1'b1, sdata_in = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic sclk_out, sdata_out, sdata_oe, irq, done;

  int total = 0, failed = 0, irqs = 0, lows = 0, falls = 0;
  logic [W-1:0] cap;

  always #10 clk = ~clk;

  sio_shifter #(.W(W), .HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ext_mode(ext_mode),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .irq(irq), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (irq) irqs++;
    if (!sclk_out) lows++;
  endtask

  task automatic do_write(input logic [W-1:0] val);
    wr_data = val;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    irqs = 0; lows = 0; falls = 0; cap = '0;
    chk("R2 rd_data after write", rd_data, val);
    chk("R2 done cleared by write", done, 0);
    chk("R2 oe set by write", sdata_oe, 1);
  endtask

  task automatic run_int(input logic [W-1:0] tx, input logic [W-1:0] rx);
    logic prev;
    ext_mode = 1'b0;
    do_write(tx);
    prev = sclk_out;
    for (int i = 0; i < 16*HALF + 8; i++) begin
      step();
      if (prev && !sclk_out) begin
        if (falls < W) begin
          cap[falls] = sdata_out;
          sdata_in = rx[falls];
        end
        falls++;
      end
      prev = sclk_out;
    end
    chk("R3 internal tx bits", cap, tx);
    chk("R4 internal rx byte", rd_data, rx);
    chk("R5 falling edges", falls, W);
    chk("R5 low cycles", lows, W*HALF);
    chk("R5 clock parked high", sclk_out, 1);
    chk("R6 done set", done, 1);
    chk("R6 pin released", sdata_oe, 0);
    chk("R9 single irq", irqs, 1);
  endtask

  task automatic ext_edges(input logic [W-1:0] rx);
    for (int i = 0; i < W; i++) begin
      sclk_in = 1'b0;
      sdata_in = rx[i];
      repeat (EXT_HP) step();
      cap[i] = sdata_out;
      sclk_in = 1'b1;
      repeat (EXT_HP) step();
    end
  endtask

  task automatic run_ext(input logic [W-1:0] tx, input logic [W-1:0] rx);
    ext_mode = 1'b1;
    do_write(tx);
    ext_edges(rx);
    chk("R3 external tx bits", cap, tx);
    chk("R4 external rx byte", rd_data, rx);
    chk("R7 done set", done, 1);
    chk("R7 pin stays driven", sdata_oe, 1);
    chk("R7 internal clock idle", sclk_out, 1);
    chk("R9 single irq", irqs, 1);
  endtask

  initial begin
    #(20 * 200000);
    total++;
    failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sclk_out", sclk_out, 1);
    chk("R1 sdata_oe", sdata_oe, 0);
    chk("R1 irq", irq, 0);
    chk("R1 done", done, 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][16]) run_ext(VEC[v][15:8], VEC[v][7:0]);
      else run_int(VEC[v][15:8], VEC[v][7:0]);
    end

    // R8 read clears the flag, data unchanged
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8 done cleared by read", done, 0);
    chk("R8 rd_data kept", rd_data, 8'h01);

    // R7 external clock keeps shifting after completion
    run_ext(8'h96, 8'h1E);
    irqs = 0;
    ext_edges(8'h77);
    chk("R7 shifting continues", rd_data, 8'h77);
    chk("R7 no extra irq", irqs, 0);
    chk("R7 oe still driven", sdata_oe, 1);
    chk("R7 done stays set", done, 1);
    chk("R3 post-completion bits", cap, 8'h1E);

    // R2 restart with a write in the middle of an internal transfer
    ext_mode = 1'b0;
    do_write(8'hF0);
    repeat (5*HALF) step();
    run_int(8'h3C, 8'hA6);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule